// File: doc/BRIEF.md
# Cache-Centric Home Controller for a Two-State Snooping Protocol

This block sits on the memory side of a shared, atomic snooping bus that uses a two-state (Valid/Invalid) write-back protocol. It keeps one state bit and one data word for each block in a small register array. The state names describe the caches, not memory. A block marked idle means no cache holds it. A block marked held means exactly one cache owns it and will answer requests for it.

The controller watches each bus message. A fetch request for an idle block gets the stored word back one cycle later, tagged with the requester's identifier, and the block becomes held. A fetch request for a held block gets no answer, because the owning cache answers it. A write-back to a held block stores the carried word and returns the block to idle.

The controller reports two kinds of event that should never happen, each as a one-cycle pulse:
- a write-back to an idle block;
- any message that lands in the cycle reserved for the controller's own reply.

Top module: `mem_vi_home`

## Requirements
- R1: After reset every block is idle, every stored word is zero, and `resp_valid`, `err_put_inv` and `err_collide` are low.
- R2: A fetch (`bus_kind` = 0) to an idle block makes `resp_valid` high in the next cycle, with `resp_dst` equal to the requester's `bus_src`, `resp_addr` equal to the block address and `resp_data` equal to the stored word. The block becomes held.
- R3: A fetch to a held block produces no reply, and the block stays held.
- R4: A write-back (`bus_kind` = 1) to a held block stores `bus_data` at that address and makes the block idle again. No error is raised.
- R5: A write-back to an idle block raises `err_put_inv` for one cycle. Stored data and state are left unchanged, and no reply is sent.
- R6: A message presented in the cycle when `resp_valid` is high raises `err_collide` for one cycle and is otherwise ignored.
- R7: `resp_valid` lasts exactly one cycle. Each block's state and data are independent of all other addresses, including the lowest and the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A message is on the bus this cycle |
| bus_kind | input | 1 | 0 = fetch request, 1 = write-back with data |
| bus_addr | input | ADDR_W | Block address |
| bus_src | input | ID_W | Identifier of the sending cache |
| bus_data | input | DATA_W | Write-back data |
| resp_valid | output | 1 | Data reply from memory this cycle |
| resp_dst | output | ID_W | Requester the reply is meant for |
| resp_addr | output | ADDR_W | Block address of the reply |
| resp_data | output | DATA_W | Reply data |
| err_put_inv | output | 1 | Pulse: write-back seen for an idle block |
| err_collide | output | 1 | Pulse: message overlapped the reply cycle |

## Verification
The bench sends a second fetch to a block that is already held. A design that reads the naming the memory-permission way would answer it and drive a duplicate reply. The bench reads a written-back word back through a later fetch, and reads an illegal write-back's address back the same way. This catches a design that drops the data, and one that stores data from a write-back to an idle block. The bench also sends a message straight into the reply cycle, then fetches that address again. A design that quietly served the overlapping message would give no answer there and raise no collision flag. Writes at the top address are checked against the lowest address, which catches broken address decoding.

// File: rtl/mem_vi_home.sv
module mem_vi_home #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_kind,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ID_W-1:0]   bus_src,
  input  logic [DATA_W-1:0] bus_data,
  output logic              resp_valid,
  output logic [ID_W-1:0]   resp_dst,
  output logic [ADDR_W-1:0] resp_addr,
  output logic [DATA_W-1:0] resp_data,
  output logic              err_put_inv,
  output logic              err_collide
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  blk_state;
  logic [DATA_W-1:0] store [DEPTH];

  wire accept = bus_valid && !resp_valid;
  wire held   = blk_state[bus_addr];
  wire serve  = accept && !bus_kind && !held;
  wire absorb = accept &&  bus_kind &&  held;
  wire stray  = accept &&  bus_kind && !held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_state   <= '0;
      resp_valid  <= 1'b0;
      resp_dst    <= '0;
      resp_addr   <= '0;
      resp_data   <= '0;
      err_put_inv <= 1'b0;
      err_collide <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      resp_valid  <= serve;
      err_put_inv <= stray;
      err_collide <= bus_valid && resp_valid;
      if (serve) begin
        resp_dst            <= bus_src;
        resp_addr           <= bus_addr;
        resp_data           <= store[bus_addr];
        blk_state[bus_addr] <= 1'b1;
      end
      if (absorb) begin
        store[bus_addr]     <= bus_data;
        blk_state[bus_addr] <= 1'b0;
      end
    end
  end
endmodule

module mem_vi_home_chk #(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_kind,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [ID_W-1:0]        bus_src,
  input logic                   resp_valid,
  input logic [ID_W-1:0]        resp_dst,
  input logic                   err_put_inv,
  input logic                   err_collide,
  input logic [(1<<ADDR_W)-1:0] blk_state
);
  a_r2_idle_fetch_replies: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_kind && !resp_valid && !blk_state[bus_addr]
    |=> resp_valid && resp_dst == $past(bus_src) && blk_state[$past(bus_addr)]);

  a_r3_held_fetch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_kind && !resp_valid && blk_state[bus_addr]
    |=> !resp_valid && blk_state[$past(bus_addr)]);

  a_r4_writeback_frees: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_kind && !resp_valid && blk_state[bus_addr]
    |=> !blk_state[$past(bus_addr)] && !err_put_inv);

  a_r5_stray_writeback_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_kind && !resp_valid && !blk_state[bus_addr]
    |=> err_put_inv && !resp_valid && $stable(blk_state));

  a_r6_overlap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && resp_valid |=> err_collide && $stable(blk_state));

  a_r7_reply_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

bind mem_vi_home mem_vi_home_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_kind(bus_kind),
  .bus_addr(bus_addr), .bus_src(bus_src), .resp_valid(resp_valid),
  .resp_dst(resp_dst), .err_put_inv(err_put_inv), .err_collide(err_collide),
  .blk_state(blk_state)
);

// File: tb/tb_mem_vi_home.sv
`timescale 1ns/1ps
module tb_mem_vi_home;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int ID_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_kind = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [ID_W-1:0]   bus_src = '0;
  logic [DATA_W-1:0] bus_data = '0;
  logic              resp_valid;
  logic [ID_W-1:0]   resp_dst;
  logic [ADDR_W-1:0] resp_addr;
  logic [DATA_W-1:0] resp_data;
  logic              err_put_inv;
  logic              err_collide;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mem_vi_home #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_addr(bus_addr), .bus_src(bus_src), .bus_data(bus_data),
    .resp_valid(resp_valid), .resp_dst(resp_dst), .resp_addr(resp_addr),
    .resp_data(resp_data), .err_put_inv(err_put_inv), .err_collide(err_collide)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one message for one cycle; outputs are sampled on the following negedge.
  task automatic send(input logic kind, input logic [ADDR_W-1:0] a,
                      input logic [ID_W-1:0] s, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = kind; bus_addr = a; bus_src = s; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "resp_valid", resp_valid, 0);
    check("R1", "err_put_inv", err_put_inv, 0);
    check("R1", "err_collide", err_collide, 0);
  endtask

  task automatic t_fetch_idle();
    send(1'b0, 4'd3, 2'd2, '0);
    check("R2", "resp_valid", resp_valid, 1);
    check("R2", "resp_dst", resp_dst, 2);
    check("R2", "resp_addr", resp_addr, 3);
    check("R1", "reset data", resp_data, 0);
    @(negedge clk);
    check("R7", "reply one cycle", resp_valid, 0);
  endtask

  task automatic t_fetch_held();
    send(1'b0, 4'd3, 2'd1, '0);
    check("R3", "no reply when held", resp_valid, 0);
    send(1'b1, 4'd3, 2'd2, 32'hA5A5_0001);
    check("R3", "still held, no error", err_put_inv, 0);
  endtask

  task automatic t_writeback_roundtrip();
    send(1'b0, 4'd3, 2'd0, '0);
    check("R4", "idle after write-back", resp_valid, 1);
    check("R4", "stored word", resp_data, 32'hA5A5_0001);
    check("R2", "resp_dst", resp_dst, 0);
    send(1'b1, 4'd3, 2'd0, 32'h0000_1234);
    check("R4", "no error", err_put_inv, 0);
  endtask

  task automatic t_stray_writeback();
    send(1'b1, 4'd7, 2'd1, 32'hFFFF_FFFF);
    check("R5", "err_put_inv", err_put_inv, 1);
    check("R5", "no reply", resp_valid, 0);
    send(1'b0, 4'd7, 2'd1, '0);
    check("R5", "error pulse cleared", err_put_inv, 0);
    check("R5", "state unchanged, reply", resp_valid, 1);
    check("R5", "data unchanged", resp_data, 0);
    send(1'b1, 4'd7, 2'd1, '0);
  endtask

  task automatic t_overlap();
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = 1'b0; bus_addr = 4'd5; bus_src = 2'd1;
    @(negedge clk);
    check("R2", "first reply", resp_valid, 1);
    bus_addr = 4'd9; bus_src = 2'd3;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R6", "err_collide", err_collide, 1);
    check("R7", "no second reply", resp_valid, 0);
    send(1'b0, 4'd9, 2'd3, '0);
    check("R6", "ignored fetch left block idle", resp_valid, 1);
    check("R6", "resp_dst", resp_dst, 3);
    check("R6", "collision pulse cleared", err_collide, 0);
    send(1'b1, 4'd5, 2'd1, '0);
    send(1'b1, 4'd9, 2'd3, '0);
    check("R6", "both blocks held", err_put_inv, 0);
  endtask

  task automatic t_edges();
    send(1'b0, 4'd15, 2'd2, '0);
    check("R7", "top address reply", resp_addr, 15);
    send(1'b1, 4'd15, 2'd2, 32'hDEAD_BEEF);
    check("R7", "top write-back ok", err_put_inv, 0);
    send(1'b0, 4'd0, 2'd1, '0);
    check("R7", "low address independent", resp_data, 0);
    check("R7", "low address reply", resp_valid, 1);
    send(1'b0, 4'd15, 2'd0, '0);
    check("R7", "top address data", resp_data, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fetch_idle();
    t_fetch_held();
    t_writeback_roundtrip();
    t_stray_writeback();
    t_overlap();
    t_edges();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule